// File: doc/BRIEF.md
# Congruence Group Line Swap Controller

This block tracks where lines live in a two-tier memory in which the fast stacked tier and the slower off-chip tier are visible to software together. Memory is split into congruence groups of four equal-sized lines. Physical slot 0 of a group is in the fast tier and slots 1 to 3 are off-chip. Lines are never copied. Instead, a requested line that sits off-chip trades places with the line that holds the fast slot. Each group keeps a small permutation table that records the current slot of every logical line.

For each request, given a group index and a logical line id, the controller reads that group's table. It returns a response carrying the hit flag, the line's physical slot and the table as read; in a real system the table would come back alongside the fast-tier data. A request to an off-chip line also raises a swap command. The command is held until the memory side accepts it with a ready handshake, and the table is rewritten in that same cycle. DRAM timing and the data transfer itself are outside this block.

Top module: `line_swap_ctrl`

## Requirements
- R1: After reset, every group holds the identity mapping: logical line k is in physical slot k, so the group map reads 8'hE4.
- R2: The group map packs a 2-bit slot code per logical line. Bits [2k+1:2k] give the slot of logical line k. Slot 0 is the fast tier and slots 1, 2 and 3 are off-chip.
- R3: A request whose line is in slot 0 is a hit. The response has rsp_hit_o=1 and rsp_slot_o=0. No swap is issued and the table stays unchanged.
- R4: A request whose line is off-chip is a miss. The response has rsp_hit_o=0 and rsp_slot_o set to the line's slot. A swap command is raised with the group, fast slot 0, the off-chip slot and the logical id of the displaced fast-slot occupant.
- R5: The table is rewritten in the cycle where swp_valid_o and swp_ready_i are both high, and tbl_wr_o pulses in that cycle. After the rewrite, the requested line is in slot 0 and the displaced line is in the vacated off-chip slot. tbl_group_o and tbl_map_o carry the group and its new map.
- R6: While a swap command waits for ready, req_ready_o is low, no request is taken, and the command fields hold steady.
- R7: The response appears for exactly one cycle, one clock edge after the request is accepted.
- R8: The four slot codes of every group always form a permutation of 0 to 3.
- R9: A swap changes only the table of its own group.
- R10: Starting from the identity mapping in one group, the requests line1, line1, line2 give a swap of lines 0 and 1, then a hit, then a swap of lines 2 and 1. The final map is 8'hC9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken (no swap pending) |
| req_group_i | input | GRP_W | Congruence group index |
| req_line_i | input | 2 | Logical line id within the group |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_hit_o | output | 1 | Line was in the fast slot |
| rsp_slot_o | output | 2 | Physical slot holding the line at lookup time |
| rsp_map_o | output | 8 | Group map as read at lookup time |
| swp_valid_o | output | 1 | Swap command pending |
| swp_ready_i | input | 1 | Memory side accepts the swap command |
| swp_group_o | output | GRP_W | Group of the swap |
| swp_fast_slot_o | output | 2 | Fast slot involved (always 0) |
| swp_far_slot_o | output | 2 | Off-chip slot involved |
| swp_victim_o | output | 2 | Logical line leaving the fast slot |
| tbl_wr_o | output | 1 | Table rewrite pulse |
| tbl_group_o | output | GRP_W | Group being rewritten |
| tbl_map_o | output | 8 | New map of that group |

## Verification
First, the bench requests line 0 of every group after reset. Each must hit with the identity map, which shows that nothing moves on a hit. Next, it runs the fixed line1, line1, line2 sequence in one group. This separates a swap from a hit and shows that the displaced line lands in the correct vacated slot. A long arithmetic sweep across all groups and lines, with varied ready stalls, is checked against a bench-side permutation model. This shows whether the table rewrites stay consistent over time, whether the groups stay isolated, and whether requests are held off while a swap is pending. A second reset in mid-run must bring every group back to the identity map.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int LINES   = 4;
  localparam int SLOT_W  = 2;
  localparam int MAP_W   = LINES * SLOT_W;

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [MAP_W-1:0]  map_t;

  localparam slot_t FAST_SLOT = '0;

  function automatic map_t identity_map();
    map_t m;
    for (int k = 0; k < LINES; k++) m[k*SLOT_W +: SLOT_W] = slot_t'(k);
    return m;
  endfunction

  function automatic slot_t loc_of(map_t m, slot_t line);
    return m[line*SLOT_W +: SLOT_W];
  endfunction

  function automatic logic is_perm(map_t m);
    logic [LINES-1:0] seen;
    seen = '0;
    for (int k = 0; k < LINES; k++) seen[m[k*SLOT_W +: SLOT_W]] = 1'b1;
    return &seen;
  endfunction
endpackage

// File: rtl/lsc_table.sv
module lsc_table
  import lsc_pkg::*;
#(
  parameter int NUM_GROUPS = 64,
  parameter int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GRP_W-1:0] rd_group_i,
  output map_t             rd_map_o,
  input  logic             wr_en_i,
  input  logic [GRP_W-1:0] wr_group_i,
  input  map_t             wr_map_i
);
  map_t tbl_q [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    tbl_q[g] <= identity_map();
      else if (wr_en_i && wr_group_i == GRP_W'(g))    tbl_q[g] <= wr_map_i;
    end

    // R8
    perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) is_perm(tbl_q[g]));
  end

  always_comb begin
    rd_map_o = identity_map();
    for (int g = 0; g < NUM_GROUPS; g++)
      if (rd_group_i == GRP_W'(g)) rd_map_o = tbl_q[g];
  end
endmodule

// File: rtl/lsc_resolve.sv
module lsc_resolve
  import lsc_pkg::*;
(
  input  map_t  map_i,
  input  slot_t line_i,
  output logic  hit_o,
  output slot_t slot_o,
  output slot_t victim_o,
  output map_t  new_map_o
);
  always_comb begin
    slot_o   = loc_of(map_i, line_i);
    hit_o    = (slot_o == FAST_SLOT);
    victim_o = '0;
    for (int k = 0; k < LINES; k++)
      if (map_i[k*SLOT_W +: SLOT_W] == FAST_SLOT) victim_o = slot_t'(k);
    new_map_o = map_i;
    new_map_o[victim_o*SLOT_W +: SLOT_W] = slot_o;
    new_map_o[line_i*SLOT_W +: SLOT_W]   = FAST_SLOT;
  end
endmodule

// File: rtl/lsc_cmd.sv
module lsc_cmd
  import lsc_pkg::*;
#(
  parameter int GRP_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [GRP_W-1:0] group_i,
  input  slot_t            far_i,
  input  slot_t            victim_i,
  input  map_t             map_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [GRP_W-1:0] group_o,
  output slot_t            far_o,
  output slot_t            victim_o,
  output map_t             map_o,
  output logic             fire_o
);
  assign fire_o = valid_o & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      group_o  <= '0;
      far_o    <= '0;
      victim_o <= '0;
      map_o    <= '0;
    end else if (load_i) begin
      valid_o  <= 1'b1;
      group_o  <= group_i;
      far_o    <= far_i;
      victim_o <= victim_i;
      map_o    <= map_i;
    end else if (fire_o) begin
      valid_o  <= 1'b0;
    end
  end

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(far_o) && $stable(group_o) && $stable(victim_o));
  // R4
  far_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> far_o != FAST_SLOT);
endmodule

// File: rtl/line_swap_ctrl.sv
module line_swap_ctrl
  import lsc_pkg::*;
#(
  parameter int NUM_GROUPS = 64,
  parameter int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [GRP_W-1:0] req_group_i,
  input  logic [1:0]       req_line_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic [1:0]       rsp_slot_o,
  output logic [7:0]       rsp_map_o,
  output logic             swp_valid_o,
  input  logic             swp_ready_i,
  output logic [GRP_W-1:0] swp_group_o,
  output logic [1:0]       swp_fast_slot_o,
  output logic [1:0]       swp_far_slot_o,
  output logic [1:0]       swp_victim_o,
  output logic             tbl_wr_o,
  output logic [GRP_W-1:0] tbl_group_o,
  output logic [7:0]       tbl_map_o
);
  map_t  rd_map, nxt_map, cmd_map;
  logic  lk_hit, accept, fire;
  slot_t lk_slot, lk_victim;

  assign req_ready_o = ~swp_valid_o;
  assign accept      = req_valid_i & req_ready_o;

  lsc_table #(.NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_group_i (req_group_i),
    .rd_map_o   (rd_map),
    .wr_en_i    (fire),
    .wr_group_i (swp_group_o),
    .wr_map_i   (cmd_map)
  );

  lsc_resolve u_resolve (
    .map_i     (rd_map),
    .line_i    (req_line_i),
    .hit_o     (lk_hit),
    .slot_o    (lk_slot),
    .victim_o  (lk_victim),
    .new_map_o (nxt_map)
  );

  lsc_cmd #(.GRP_W(GRP_W)) u_cmd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept & ~lk_hit),
    .group_i  (req_group_i),
    .far_i    (lk_slot),
    .victim_i (lk_victim),
    .map_i    (nxt_map),
    .ready_i  (swp_ready_i),
    .valid_o  (swp_valid_o),
    .group_o  (swp_group_o),
    .far_o    (swp_far_slot_o),
    .victim_o (swp_victim_o),
    .map_o    (cmd_map),
    .fire_o   (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_slot_o  <= '0;
      rsp_map_o   <= '0;
    end else begin
      rsp_valid_o <= accept;
      if (accept) begin
        rsp_hit_o  <= lk_hit;
        rsp_slot_o <= lk_slot;
        rsp_map_o  <= rd_map;
      end
    end
  end

  assign swp_fast_slot_o = FAST_SLOT;
  assign tbl_wr_o        = fire;
  assign tbl_group_o     = swp_group_o;
  assign tbl_map_o       = cmd_map;

  // R3
  hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_hit_o |-> !swp_valid_o && rsp_slot_o == FAST_SLOT);
  // R4
  miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_hit_o |-> swp_valid_o && swp_far_slot_o == rsp_slot_o);
  // R6
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swp_valid_o |=> !rsp_valid_o);
  // R7
  lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i && req_ready_o));
  // R8
  map_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_wr_o |-> is_perm(tbl_map_o) && tbl_map_o[swp_victim_o*2 +: 2] == swp_far_slot_o);
endmodule

// File: tb/line_swap_ctrl_bench.sv
`timescale 1ns/1ps
module line_swap_ctrl_bench;
  localparam int NG = 4;
  localparam int GW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, swp_ready = 1'b0;
  logic [GW-1:0] req_group = '0;
  logic [1:0] req_line = '0;
  logic req_ready, rsp_valid, rsp_hit, swp_valid, tbl_wr;
  logic [1:0] rsp_slot, swp_fast, swp_far, swp_victim;
  logic [7:0] rsp_map, tbl_map;
  logic [GW-1:0] swp_group, tbl_group;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  int mdl [NG][4];

  always #2.5 clk = ~clk;

  line_swap_ctrl #(.NUM_GROUPS(NG)) u_line_swap_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_group_i(req_group), .req_line_i(req_line),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_slot_o(rsp_slot), .rsp_map_o(rsp_map),
    .swp_valid_o(swp_valid), .swp_ready_i(swp_ready), .swp_group_o(swp_group),
    .swp_fast_slot_o(swp_fast), .swp_far_slot_o(swp_far), .swp_victim_o(swp_victim),
    .tbl_wr_o(tbl_wr), .tbl_group_o(tbl_group), .tbl_map_o(tbl_map)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pack(int g);
    int m = 0;
    for (int k = 0; k < 4; k++) m |= mdl[g][k] << (2 * k);
    return m;
  endfunction

  function automatic bit perm8(logic [7:0] m);
    logic [3:0] s = '0;
    for (int k = 0; k < 4; k++) s[m[2*k +: 2]] = 1'b1;
    return s == 4'hF;
  endfunction

  task automatic model_reset();
    for (int g = 0; g < NG; g++)
      for (int k = 0; k < 4; k++) mdl[g][k] = k;
  endtask

  task automatic do_req(input int g, input int l, input int stall, input string tag);
    int loc, vic, oldm, newm;
    bit hit;
    @(negedge clk);
    chk(req_ready == 1'b1, "R6 ready idle", req_ready, 1);
    req_valid = 1'b1; req_group = GW'(g); req_line = 2'(l);
    loc = mdl[g][l]; hit = (loc == 0); oldm = pack(g);
    vic = 0;
    for (int k = 0; k < 4; k++) if (mdl[g][k] == 0) vic = k;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, {"R7 rsp pulse ", tag}, rsp_valid, 1);
    chk(rsp_hit == hit, {"R3/R4 hit flag ", tag}, rsp_hit, hit);
    chk(rsp_slot == 2'(loc), {"R4 slot ", tag}, rsp_slot, loc);
    chk(rsp_map == 8'(oldm), {"R2/R9 map ", tag}, rsp_map, oldm);
    chk(perm8(rsp_map), {"R8 perm ", tag}, rsp_map, oldm);
    chk(swp_valid == !hit, {"R3/R4 swap valid ", tag}, swp_valid, !hit);
    if (hit) begin
      chk(tbl_wr == 1'b0, {"R3 no write ", tag}, tbl_wr, 0);
      return;
    end
    chk(swp_group == GW'(g) && swp_fast == 2'd0 && swp_far == 2'(loc) && swp_victim == 2'(vic),
        {"R4 cmd ", tag}, {swp_group, swp_fast, swp_far, swp_victim}, {g[7:0], 2'd0, loc[1:0], vic[1:0]});
    mdl[g][l] = 0; mdl[g][vic] = loc;
    newm = pack(g);
    for (int s = 0; s < stall; s++) begin
      req_valid = 1'b1; req_group = GW'((g + 1) % NG); req_line = 2'((l + 1) % 4);
      @(negedge clk);
      chk(rsp_valid == 1'b0 && req_ready == 1'b0, {"R6 held off ", tag}, {rsp_valid, req_ready}, 0);
      chk(swp_valid && swp_far == 2'(loc) && tbl_wr == 1'b0, {"R6 cmd held ", tag}, swp_far, loc);
    end
    req_valid = 1'b0;
    swp_ready = 1'b1;
    #1;
    chk(tbl_wr == 1'b1 && tbl_group == GW'(g), {"R5 write pulse ", tag}, tbl_wr, 1);
    chk(tbl_map == 8'(newm), {"R5 new map ", tag}, tbl_map, newm);
    @(negedge clk);
    swp_ready = 1'b0;
    chk(swp_valid == 1'b0 && req_ready == 1'b1 && rsp_valid == 1'b0, {"R6 release ", tag},
        {swp_valid, req_ready, rsp_valid}, 3'b010);
  endtask

  task automatic apply_reset();
    @(negedge clk); rst_n = 1'b0;
    req_valid = 1'b0; swp_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    apply_reset();
    chk(rsp_valid == 0 && swp_valid == 0 && req_ready == 1 && tbl_wr == 0, "R1 reset outputs",
        {rsp_valid, swp_valid, req_ready, tbl_wr}, 4'b0010);
    // R1: identity in every group
    for (int g = 0; g < NG; g++) begin
      do_req(g, 0, 0, "R1");
      chk(rsp_map == 8'hE4, "R1 identity", rsp_map, 8'hE4);
    end
    // R10: line1, line1, line2 in group 2
    do_req(2, 1, 0, "R10a");
    chk(rsp_slot == 2'd1, "R10 first B from slot1", rsp_slot, 1);
    do_req(2, 1, 0, "R10b");
    chk(rsp_hit == 1'b1, "R10 second B hits", rsp_hit, 1);
    do_req(2, 2, 3, "R10c");
    chk(tbl_map == 8'hC9 && pack(2) == 8'hC9, "R10 final map", tbl_map, 8'hC9);
    // R9: other groups untouched
    for (int g = 0; g < NG; g++) if (g != 2) begin
      do_req(g, 0, 0, "R9");
      chk(rsp_map == 8'hE4, "R9 isolation", rsp_map, 8'hE4);
    end
    // sweep
    for (int i = 0; i < 400; i++)
      do_req((i * 5 + i / 7) % NG, (i * 3 + i / 4 + i / 16) % 4, i % 3, "sweep");
    // reset again: back to identity
    apply_reset();
    for (int g = 0; g < NG; g++) begin
      do_req(g, 0, 0, "R1 rst2");
      chk(rsp_map == 8'hE4, "R1 identity after reset", rsp_map, 8'hE4);
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule